// File: doc/BRIEF.md
# Display Controller Register and Interrupt Unit

This unit is the software-visible control face of a display controller. A processor programs it over a simple register bus that completes in one cycle: overall control, configuration, four timing words, two background colours, two transparency keys, a scan-line compare value, the sizes of the digital output, the LCD panel and one graphics layer, and that layer's position, base addresses, attributes, FIFO thresholds and address increments. Only full 32-bit accesses take effect. Each register keeps only its defined bits.

Sizes are held inside as true pixel and line counts. Software sees them as count-minus-one fields, and a size of 1 by 1 is the state after reset. An interrupt status and enable pair collects event pulses from the rest of the display pipeline and drives a level interrupt. Any write that changes what appears on the screen latches a redraw flag. The flag stays set until the pipeline acknowledges it with a clear pulse. A soft-reset bit in the system-configuration register returns every register to its reset value.

Top module: `dispc_regbank`

## Requirements
- R1: An access counts only when `bus_sel` is high and `bus_size` is 2'b10 (word). The code 2'b00 means byte and 2'b01 means halfword. A write of any other size changes no register. A read of any other size returns 0.
- R2: Word reads return fixed values at these offsets: 0x000 returns 0x20, 0x014 returns 0x1, 0x05C returns 0x7FF and 0x0A8 returns 0x100. Offsets with no register read 0, and writes to them have no effect.
- R3: After `rst_n` is released, capability (0x048) reads 0x161. The three size registers read 0, which means 1 pixel by 1 line. Every other stored register reads 0, and all outputs are low.
- R4: A word write stores the data ANDed with the register's mask: 0x010 uses 0x301B, 0x040 uses 0x07FF9FFF, 0x044 uses 0x3FFF and 0x048 uses 0x3FF. 0x04C, 0x050, 0x054 and 0x058 use 0xFFFFFF. 0x060 uses 0x7FF. 0x064 and 0x068 use 0x0FF0FF3F, 0x06C uses 0x3FFFF and 0x070 uses 0x00FF00FF. 0x0A0 uses 0x7FF and 0x0A4 uses 0x01FF01FF. 0x080, 0x084, 0x0B8, 0x0AC, 0x0B0 and 0x0B4 keep all 32 bits.
- R5: Control (0x040) bit 0 drives `lcd_en` and bit 1 drives `dig_en`. Attribute (0x0A0) bit 0 drives `layer_en`. Each output follows the cycle after the write.
- R6: The size registers are 0x078 (digital), 0x07C (LCD) and 0x08C (layer). Each holds width-1 in bits [10:0] and height-1 in bits [26:16]. The position register 0x088 holds X in [10:0] and Y in [26:16]. All other bits read 0.
- R7: Interrupt status (0x018) clears each bit that is written as 1 and leaves the others. Interrupt enable (0x01C) keeps bits [15:0].
- R8: Bit k of `evt_in` sets status bit k at the next clock edge. A set and a write-1-to-clear of the same bit in the same cycle leave the bit set.
- R9: `irq_out` is high exactly when status AND enable is nonzero. It reflects a change the cycle after the change.
- R10: A word write to any of these offsets sets `redraw_flag` at the next edge: 0x040, 0x044, 0x04C-0x058, 0x078, 0x07C, 0x080, 0x084, 0x088, 0x08C, 0x0A0, 0x0AC, 0x0B0 and 0x0B8. Writes to other offsets leave the flag unchanged.
- R11: `redraw_flag` stays set until `redraw_clr` is sampled high. When a redraw-setting write and a clear arrive in the same cycle, the flag stays set.
- R12: A word write to 0x010 with bit 1 set restores every register to its reset value, including status, enable and the redraw flag. Events in that same cycle are dropped. The system-configuration register then holds the written data ANDed with 0x301B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read request |
| evt_in | input | 16 | Event pulses that set interrupt status bits |
| irq_out | output | 1 | Level interrupt |
| lcd_en | output | 1 | LCD panel output enable |
| dig_en | output | 1 | Digital output enable |
| layer_en | output | 1 | Graphics layer enable |
| redraw_flag | output | 1 | A picture-affecting register was written |
| redraw_clr | input | 1 | Acknowledge that clears the redraw flag |

## Verification
The properties assume that `evt_in` and all bus inputs are synchronous to `clk` and stable around the rising edge. They also assume a soft reset only ever arrives as a word write to the system-configuration offset. The stimulus changes every input at the falling edge. It draws offsets from the 0x000-0x1FC window, including unmapped holes, and mixes occasional byte and halfword accesses into mostly word traffic. It sets the soft-reset bit on only a small share of system-configuration writes so that state can build up between resets.

// File: rtl/dispc_pkg.sv
package dispc_pkg;

  localparam int ADDR_W       = 12;
  localparam int DATA_W       = 32;
  localparam int IRQ_W        = 16;
  localparam int SZ_W         = 11;
  localparam int CNT_W        = SZ_W + 1;
  localparam int H_LSB        = 16;
  localparam int SOFT_RST_BIT = 1;
  localparam int NPLAIN       = 22;
  localparam int NDIM         = 3;

  localparam logic [1:0] ACC_WORD = 2'b10;

  localparam logic [DATA_W-1:0] REV_VAL     = 32'h0000_0020;
  localparam logic [DATA_W-1:0] SYSSTAT_VAL = 32'h0000_0001;
  localparam logic [DATA_W-1:0] LINEMAX_VAL = 32'h0000_07FF;
  localparam logic [DATA_W-1:0] FIFOSZ_VAL  = 32'h0000_0100;

  typedef enum logic [4:0] {
    RID_NONE, RID_REV, RID_SYSCFG, RID_SYSSTAT, RID_IRQST, RID_IRQEN,
    RID_CTRL, RID_CFG, RID_CAP, RID_BG0, RID_BG1, RID_TK0, RID_TK1,
    RID_LINEMAX, RID_LINE, RID_TIM0, RID_TIM1, RID_TIM2, RID_TIM3,
    RID_DIGSZ, RID_LCDSZ, RID_BA0, RID_BA1, RID_POS, RID_LSZ, RID_ATTR,
    RID_THR, RID_FIFOSZ, RID_ROWINC, RID_COLINC, RID_WININC, RID_BA2
  } reg_id_e;

  // Index of selected plain registers inside the tables below
  localparam int IX_CTRL = 1;
  localparam int IX_ATTR = 17;

  localparam reg_id_e PLAIN_ID [NPLAIN] = '{
    RID_SYSCFG, RID_CTRL, RID_CFG, RID_CAP, RID_BG0, RID_BG1, RID_TK0,
    RID_TK1, RID_LINE, RID_TIM0, RID_TIM1, RID_TIM2, RID_TIM3, RID_BA0,
    RID_BA1, RID_BA2, RID_POS, RID_ATTR, RID_THR, RID_ROWINC, RID_COLINC,
    RID_WININC
  };

  localparam logic [DATA_W-1:0] PLAIN_MASK [NPLAIN] = '{
    32'h0000_301B, 32'h07FF_9FFF, 32'h0000_3FFF, 32'h0000_03FF,
    32'h00FF_FFFF, 32'h00FF_FFFF, 32'h00FF_FFFF, 32'h00FF_FFFF,
    32'h0000_07FF, 32'h0FF0_FF3F, 32'h0FF0_FF3F, 32'h0003_FFFF,
    32'h00FF_00FF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'h07FF_07FF, 32'h0000_07FF, 32'h01FF_01FF, 32'hFFFF_FFFF,
    32'hFFFF_FFFF, 32'hFFFF_FFFF
  };

  localparam logic [DATA_W-1:0] PLAIN_RST [NPLAIN] = '{
    32'h0, 32'h0, 32'h0, 32'h0000_0161, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0
  };

  localparam reg_id_e DIM_ID [NDIM] = '{RID_DIGSZ, RID_LCDSZ, RID_LSZ};

  function automatic reg_id_e decode_offset(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_W'('h000): return RID_REV;
      ADDR_W'('h010): return RID_SYSCFG;
      ADDR_W'('h014): return RID_SYSSTAT;
      ADDR_W'('h018): return RID_IRQST;
      ADDR_W'('h01C): return RID_IRQEN;
      ADDR_W'('h040): return RID_CTRL;
      ADDR_W'('h044): return RID_CFG;
      ADDR_W'('h048): return RID_CAP;
      ADDR_W'('h04C): return RID_BG0;
      ADDR_W'('h050): return RID_BG1;
      ADDR_W'('h054): return RID_TK0;
      ADDR_W'('h058): return RID_TK1;
      ADDR_W'('h05C): return RID_LINEMAX;
      ADDR_W'('h060): return RID_LINE;
      ADDR_W'('h064): return RID_TIM0;
      ADDR_W'('h068): return RID_TIM1;
      ADDR_W'('h06C): return RID_TIM2;
      ADDR_W'('h070): return RID_TIM3;
      ADDR_W'('h078): return RID_DIGSZ;
      ADDR_W'('h07C): return RID_LCDSZ;
      ADDR_W'('h080): return RID_BA0;
      ADDR_W'('h084): return RID_BA1;
      ADDR_W'('h088): return RID_POS;
      ADDR_W'('h08C): return RID_LSZ;
      ADDR_W'('h0A0): return RID_ATTR;
      ADDR_W'('h0A4): return RID_THR;
      ADDR_W'('h0A8): return RID_FIFOSZ;
      ADDR_W'('h0AC): return RID_ROWINC;
      ADDR_W'('h0B0): return RID_COLINC;
      ADDR_W'('h0B4): return RID_WININC;
      ADDR_W'('h0B8): return RID_BA2;
      default:        return RID_NONE;
    endcase
  endfunction

  function automatic logic is_picture(input reg_id_e id);
    case (id)
      RID_CTRL, RID_CFG, RID_BG0, RID_BG1, RID_TK0, RID_TK1,
      RID_DIGSZ, RID_LCDSZ, RID_BA0, RID_BA1, RID_BA2, RID_POS,
      RID_LSZ, RID_ATTR, RID_ROWINC, RID_COLINC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dispc_bus_decode.sv
module dispc_bus_decode
  import dispc_pkg::*;
(
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              soft_req,
  output logic              wr_stb,
  output logic              rd_stb,
  output reg_id_e           reg_id,
  output logic              soft_rst
);

  logic word_ok;

  always_comb begin
    word_ok  = bus_sel && (bus_size == ACC_WORD);
    wr_stb   = word_ok && bus_wr;
    rd_stb   = word_ok && !bus_wr;
    reg_id   = decode_offset(bus_addr);
    soft_rst = wr_stb && (reg_id == RID_SYSCFG) && soft_req;
  end

endmodule

// File: rtl/dispc_irq_ctrl.sv
module dispc_irq_ctrl
  import dispc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             st_wr,
  input  logic             en_wr,
  input  logic [IRQ_W-1:0] wbits,
  input  logic [IRQ_W-1:0] evt_in,
  output logic [IRQ_W-1:0] st_q,
  output logic [IRQ_W-1:0] en_q,
  output logic             irq_out
);

  logic [IRQ_W-1:0] clr_mask;
  logic [IRQ_W-1:0] st_d;
  logic [IRQ_W-1:0] en_d;
  logic             st_ce;
  logic             en_ce;

  // Next state: an event wins over a same-cycle clear; soft reset wins over all
  always_comb begin
    clr_mask = st_wr ? wbits : '0;
    st_d     = soft_rst ? '0 : ((st_q & ~clr_mask) | evt_in);
    st_ce    = soft_rst | st_wr | (|evt_in);
    en_d     = soft_rst ? '0 : wbits;
    en_ce    = soft_rst | en_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      if (st_ce) st_q <= st_d;
      if (en_ce) en_q <= en_d;
    end
  end

  assign irq_out = |(st_q & en_q);

endmodule

// File: rtl/dispc_redraw.sv
module dispc_redraw (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic set_req,
  input  logic clr_req,
  output logic flag_q
);

  logic flag_d;
  logic flag_ce;

  // Priority: soft reset, then a picture write, then the acknowledge
  always_comb begin
    flag_ce = soft_rst | set_req | clr_req;
    if (soft_rst)     flag_d = 1'b0;
    else if (set_req) flag_d = 1'b1;
    else              flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

endmodule

// File: rtl/dispc_cfg_regs.sv
module dispc_cfg_regs
  import dispc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_stb,
  input  reg_id_e           wr_id,
  input  logic [DATA_W-1:0] wdata,
  input  reg_id_e           rd_id,
  output logic [DATA_W-1:0] rd_val,
  output logic              lcd_en,
  output logic              dig_en,
  output logic              layer_en
);

  logic [DATA_W-1:0] plain_q  [NPLAIN];
  logic [DATA_W-1:0] plain_rd [NPLAIN];
  logic [DATA_W-1:0] dim_rd   [NDIM];

  // Masked registers: a hit loads the masked data, a soft reset loads the reset
  // value; the system-config hit also covers the soft-reset cycle itself
  for (genvar i = 0; i < NPLAIN; i++) begin : g_plain
    logic              hit;
    logic              ce;
    logic [DATA_W-1:0] d;
    logic [DATA_W-1:0] q;

    always_comb begin
      hit = wr_stb && (wr_id == PLAIN_ID[i]);
      ce  = hit | soft_rst;
      d   = hit ? (wdata & PLAIN_MASK[i]) : PLAIN_RST[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= PLAIN_RST[i];
      else if (ce) q <= d;
    end

    assign plain_q[i]  = q;
    assign plain_rd[i] = (rd_id == PLAIN_ID[i]) ? q : '0;
  end

  // Size registers kept as real counts, exchanged as count-minus-one fields
  for (genvar j = 0; j < NDIM; j++) begin : g_dim
    logic             hit;
    logic             ce;
    logic [CNT_W-1:0] w_d, h_d;
    logic [CNT_W-1:0] w_q, h_q;
    logic [CNT_W-1:0] w_m1, h_m1;

    always_comb begin
      hit = wr_stb && (wr_id == DIM_ID[j]);
      ce  = hit | soft_rst;
      if (hit) begin
        w_d = CNT_W'(wdata[SZ_W-1:0]) + CNT_W'(1);
        h_d = CNT_W'(wdata[H_LSB +: SZ_W]) + CNT_W'(1);
      end else begin
        w_d = CNT_W'(1);
        h_d = CNT_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w_q <= CNT_W'(1);
        h_q <= CNT_W'(1);
      end else if (ce) begin
        w_q <= w_d;
        h_q <= h_d;
      end
    end

    always_comb begin
      w_m1 = w_q - CNT_W'(1);
      h_m1 = h_q - CNT_W'(1);
    end

    assign dim_rd[j] = (rd_id != DIM_ID[j]) ? '0 :
                       {{(DATA_W-H_LSB-SZ_W){1'b0}}, h_m1[SZ_W-1:0],
                        {(H_LSB-SZ_W){1'b0}}, w_m1[SZ_W-1:0]};
  end

  always_comb begin
    case (rd_id)
      RID_REV:     rd_val = REV_VAL;
      RID_SYSSTAT: rd_val = SYSSTAT_VAL;
      RID_LINEMAX: rd_val = LINEMAX_VAL;
      RID_FIFOSZ:  rd_val = FIFOSZ_VAL;
      default:     rd_val = '0;
    endcase
    for (int i = 0; i < NPLAIN; i++) rd_val = rd_val | plain_rd[i];
    for (int j = 0; j < NDIM; j++)   rd_val = rd_val | dim_rd[j];
  end

  assign lcd_en   = plain_q[IX_CTRL][0];
  assign dig_en   = plain_q[IX_CTRL][1];
  assign layer_en = plain_q[IX_ATTR][0];

endmodule

// File: rtl/dispc_regbank.sv
module dispc_regbank
  import dispc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [IRQ_W-1:0]  evt_in,
  output logic              irq_out,
  output logic              lcd_en,
  output logic              dig_en,
  output logic              layer_en,
  output logic              redraw_flag,
  input  logic              redraw_clr
);

  logic              wr_stb;
  logic              rd_stb;
  reg_id_e           reg_id;
  logic              soft_rst;
  logic [IRQ_W-1:0]  st_q;
  logic [IRQ_W-1:0]  en_q;
  logic [DATA_W-1:0] cfg_rd;
  logic              pic_wr;

  dispc_bus_decode i_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_size (bus_size),
    .bus_addr (bus_addr),
    .soft_req (bus_wdata[SOFT_RST_BIT]),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .reg_id   (reg_id),
    .soft_rst (soft_rst)
  );

  dispc_irq_ctrl i_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .st_wr    (wr_stb && (reg_id == RID_IRQST)),
    .en_wr    (wr_stb && (reg_id == RID_IRQEN)),
    .wbits    (bus_wdata[IRQ_W-1:0]),
    .evt_in   (evt_in),
    .st_q     (st_q),
    .en_q     (en_q),
    .irq_out  (irq_out)
  );

  assign pic_wr = wr_stb && is_picture(reg_id);

  dispc_redraw i_redraw (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .set_req  (pic_wr),
    .clr_req  (redraw_clr),
    .flag_q   (redraw_flag)
  );

  dispc_cfg_regs i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .wr_stb   (wr_stb),
    .wr_id    (reg_id),
    .wdata    (bus_wdata),
    .rd_id    (rd_stb ? reg_id : RID_NONE),
    .rd_val   (cfg_rd),
    .lcd_en   (lcd_en),
    .dig_en   (dig_en),
    .layer_en (layer_en)
  );

  always_comb begin
    if (!rd_stb)                    bus_rdata = '0;
    else if (reg_id == RID_IRQST)   bus_rdata = {{(DATA_W-IRQ_W){1'b0}}, st_q};
    else if (reg_id == RID_IRQEN)   bus_rdata = {{(DATA_W-IRQ_W){1'b0}}, en_q};
    else                            bus_rdata = cfg_rd;
  end

endmodule

// File: rtl/dispc_regbank_chk.sv
module dispc_regbank_chk
  import dispc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [1:0]        bus_size,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [IRQ_W-1:0]  evt_in,
  input logic              irq_out,
  input logic              lcd_en,
  input logic              dig_en,
  input logic              layer_en,
  input logic              redraw_flag,
  input logic              redraw_clr,
  input logic              wr_stb,
  input reg_id_e           reg_id,
  input logic              soft_rst,
  input logic [IRQ_W-1:0]  st_q,
  input logic [IRQ_W-1:0]  en_q
);

  AST_NARROW_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_size != ACC_WORD) |-> (bus_rdata == '0)); // R1

  AST_NARROW_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_size != ACC_WORD)
      |=> ($stable(lcd_en) && $stable(dig_en) && $stable(layer_en))); // R1

  AST_EVT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((st_q & $past(evt_in)) == $past(evt_in))); // R8

  AST_EVT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && ((evt_in & en_q) != '0) && !(wr_stb && reg_id == RID_IRQEN))
      |=> irq_out); // R9

  AST_PIC_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && is_picture(reg_id)) |=> redraw_flag); // R10

  AST_REDRAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (redraw_flag && !redraw_clr && !soft_rst) |=> redraw_flag); // R11

  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!lcd_en && !dig_en && !layer_en && !irq_out &&
                  !redraw_flag && st_q == '0 && en_q == '0)); // R12

endmodule

bind dispc_regbank dispc_regbank_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_size    (bus_size),
  .bus_rdata   (bus_rdata),
  .evt_in      (evt_in),
  .irq_out     (irq_out),
  .lcd_en      (lcd_en),
  .dig_en      (dig_en),
  .layer_en    (layer_en),
  .redraw_flag (redraw_flag),
  .redraw_clr  (redraw_clr),
  .wr_stb      (wr_stb),
  .reg_id      (reg_id),
  .soft_rst    (soft_rst),
  .st_q        (st_q),
  .en_q        (en_q)
);

// File: tb/test_dispc_regbank.sv
module test_dispc_regbank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_size;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] evt_in;
  logic        irq_out, lcd_en, dig_en, layer_en, redraw_flag, redraw_clr;

  always #10 clk = ~clk;

  dispc_regbank i_dispc_regbank (
    .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
    .bus_size (bus_size), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .evt_in (evt_in), .irq_out (irq_out),
    .lcd_en (lcd_en), .dig_en (dig_en), .layer_en (layer_en),
    .redraw_flag (redraw_flag), .redraw_clr (redraw_clr)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string tag_override = "";

  logic [31:0] mreg [0:1023];
  logic [15:0] mst, men;
  logic        mrd;

  localparam logic [11:0] OFFS [36] = '{
    12'h000, 12'h010, 12'h014, 12'h018, 12'h01C, 12'h040, 12'h044, 12'h048,
    12'h04C, 12'h050, 12'h054, 12'h058, 12'h05C, 12'h060, 12'h064, 12'h068,
    12'h06C, 12'h070, 12'h078, 12'h07C, 12'h080, 12'h084, 12'h088, 12'h08C,
    12'h0A0, 12'h0A4, 12'h0A8, 12'h0AC, 12'h0B0, 12'h0B4, 12'h0B8, 12'h074,
    12'h0BC, 12'h100, 12'h1FC, 12'h040
  };

  function automatic logic [31:0] mask_of(input logic [11:0] a);
    case (a)
      12'h010: return 32'h0000_301B;
      12'h040: return 32'h07FF_9FFF;
      12'h044: return 32'h0000_3FFF;
      12'h048: return 32'h0000_03FF;
      12'h04C, 12'h050, 12'h054, 12'h058: return 32'h00FF_FFFF;
      12'h060: return 32'h0000_07FF;
      12'h064, 12'h068: return 32'h0FF0_FF3F;
      12'h06C: return 32'h0003_FFFF;
      12'h070: return 32'h00FF_00FF;
      12'h078, 12'h07C, 12'h088, 12'h08C: return 32'h07FF_07FF;
      12'h0A0: return 32'h0000_07FF;
      12'h0A4: return 32'h01FF_01FF;
      12'h080, 12'h084, 12'h0B8, 12'h0AC, 12'h0B0, 12'h0B4: return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit is_pic(input logic [11:0] a);
    case (a)
      12'h040, 12'h044, 12'h04C, 12'h050, 12'h054, 12'h058, 12'h078, 12'h07C,
      12'h080, 12'h084, 12'h088, 12'h08C, 12'h0A0, 12'h0AC, 12'h0B0,
      12'h0B8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [11:0] a, input logic [1:0] sz);
    if (tag_override != "") return tag_override;
    if (sz != 2'b10) return "R1";
    case (a)
      12'h018, 12'h01C: return "R7";
      12'h040, 12'h0A0: return "R5";
      12'h078, 12'h07C, 12'h088, 12'h08C: return "R6";
      12'h010: return "R12";
      default: return (mask_of(a) == 0) ? "R2" : "R4";
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a, input logic [1:0] sz);
    if (sz != 2'b10) return 32'h0;
    case (a)
      12'h000: return 32'h20;
      12'h014: return 32'h1;
      12'h05C: return 32'h7FF;
      12'h0A8: return 32'h100;
      12'h018: return {16'h0, mst};
      12'h01C: return {16'h0, men};
      default: return mreg[a[11:2]];
    endcase
  endfunction

  function automatic void check(input string req, input logic [31:0] act,
                                input logic [31:0] exp, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 1024; i++) mreg[i] = 32'h0;
    mreg[12'h048 >> 2] = 32'h161;
    mst = 16'h0;
    men = 16'h0;
    mrd = 1'b0;
  endfunction

  function automatic void model_update(input bit sel, input bit wr, input logic [1:0] sz,
                                       input logic [11:0] a, input logic [31:0] d,
                                       input logic [15:0] ev, input bit cl);
    bit w;
    w = sel && wr && (sz == 2'b10);
    if (w && a == 12'h010 && d[1]) begin
      model_reset();
      mreg[12'h010 >> 2] = d & 32'h301B;
    end else begin
      if (w && a == 12'h018) mst = mst & ~d[15:0];
      mst = mst | ev;
      if (w && a == 12'h01C) men = d[15:0];
      if (w && mask_of(a) != 0) mreg[a[11:2]] = d & mask_of(a);
      if (w && is_pic(a)) mrd = 1'b1;
      else if (cl)        mrd = 1'b0;
    end
  endfunction

  function automatic void check_outs();
    check("R9",  {31'h0, irq_out},     {31'h0, |(mst & men)},        "irq_out");
    check("R5",  {31'h0, lcd_en},      {31'h0, mreg[12'h040 >> 2][0]}, "lcd_en");
    check("R5",  {31'h0, dig_en},      {31'h0, mreg[12'h040 >> 2][1]}, "dig_en");
    check("R5",  {31'h0, layer_en},    {31'h0, mreg[12'h0A0 >> 2][0]}, "layer_en");
    check("R11", {31'h0, redraw_flag}, {31'h0, mrd},                  "redraw_flag");
  endfunction

  task automatic cycle(input bit sel, input bit wr, input logic [1:0] sz,
                       input logic [11:0] a, input logic [31:0] d,
                       input logic [15:0] ev, input bit cl);
    @(negedge clk);
    check_outs();
    bus_sel = sel; bus_wr = wr; bus_size = sz; bus_addr = a;
    bus_wdata = d; evt_in = ev; redraw_clr = cl;
    #1;
    if (sel && !wr)
      check(req_of(a, sz), bus_rdata, model_read(a, sz), $sformatf("read @%h", a));
    @(posedge clk);
    model_update(sel, wr, sz, a, d, ev, cl);
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    cycle(1'b1, 1'b1, 2'b10, a, d, 16'h0, 1'b0);
  endtask

  task automatic rd32(input logic [11:0] a);
    cycle(1'b1, 1'b0, 2'b10, a, 32'h0, 16'h0, 1'b0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1-R12 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    bus_sel = 0; bus_wr = 0; bus_size = 2'b10; bus_addr = '0;
    bus_wdata = '0; evt_in = '0; redraw_clr = 0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R3: state after reset
    tag_override = "R3";
    rd32(12'h048); rd32(12'h078); rd32(12'h07C); rd32(12'h08C);
    rd32(12'h040); rd32(12'h018); rd32(12'h0A0);
    tag_override = "";

    // R2: fixed values and holes
    rd32(12'h000); rd32(12'h014); rd32(12'h05C); rd32(12'h0A8);
    wr32(12'h100, 32'hFFFF_FFFF); rd32(12'h100);

    // R1: narrow accesses
    cycle(1'b1, 1'b1, 2'b01, 12'h040, 32'h3, 16'h0, 1'b0);
    cycle(1'b1, 1'b1, 2'b00, 12'h0A0, 32'h1, 16'h0, 1'b0);
    rd32(12'h040);
    wr32(12'h044, 32'h1234);
    cycle(1'b1, 1'b0, 2'b00, 12'h044, 32'h0, 16'h0, 1'b0);
    cycle(1'b1, 1'b0, 2'b01, 12'h044, 32'h0, 16'h0, 1'b0);

    // R6: count-minus-one fields, extremes
    wr32(12'h08C, 32'hFFFF_FFFF); rd32(12'h08C);
    wr32(12'h078, 32'h0005_0003); rd32(12'h078);
    wr32(12'h088, 32'hF8AB_FCDE); rd32(12'h088);

    // R8: set beats clear on the same bit
    wr32(12'h01C, 32'hFFFF_0003);
    cycle(1'b1, 1'b0, 2'b10, 12'h018, 32'h0, 16'h0001, 1'b0);
    cycle(1'b1, 1'b1, 2'b10, 12'h018, 32'h0000_0001, 16'h0001, 1'b0);
    tag_override = "R8";
    rd32(12'h018);
    tag_override = "";
    wr32(12'h018, 32'hFFFF_FFFF); rd32(12'h018);

    // R11: picture write with a same-cycle acknowledge keeps the flag
    cycle(1'b1, 1'b1, 2'b10, 12'h040, 32'h0000_0003, 16'h0, 1'b1);
    cycle(1'b0, 1'b0, 2'b10, 12'h000, 32'h0, 16'h0, 1'b1);
    wr32(12'h0B4, 32'h55); // R10: wininc does not set the flag
    wr32(12'h064, 32'hFFFF_FFFF);

    // R12: soft reset with a same-cycle event
    wr32(12'h0A0, 32'h7FF);
    cycle(1'b1, 1'b0, 2'b10, 12'h000, 32'h0, 16'h0002, 1'b0);
    cycle(1'b1, 1'b1, 2'b10, 12'h010, 32'hFFFF_FFFF, 16'h0004, 1'b0);
    tag_override = "R12";
    rd32(12'h018); rd32(12'h010); rd32(12'h048); rd32(12'h08C); rd32(12'h040);
    tag_override = "";

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      logic [1:0]  sz;
      logic [15:0] ev;
      bit          s, w, cl;
      a  = OFFS[$urandom_range(0, 35)];
      d  = $urandom();
      if (a == 12'h010) d[1] = ($urandom_range(0, 15) == 0);
      sz = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 1)) : 2'b10;
      s  = ($urandom_range(0, 7) != 0);
      w  = $urandom_range(0, 1) == 1;
      ev = ($urandom_range(0, 5) == 0) ? 16'($urandom()) & 16'($urandom()) : 16'h0;
      cl = ($urandom_range(0, 4) == 0);
      cycle(s, w, sz, a, d, ev, cl);
    end

    cycle(1'b0, 1'b0, 2'b10, 12'h000, 32'h0, 16'h0, 1'b0);
    @(negedge clk);
    check_outs();
    done = 1;
    summary();
    $finish;
  end

endmodule